// File: doc/BRIEF.md
# Hardwired 8-bit Harvard Processor Core

A small multi-cycle 8-bit processor with separate instruction and data memories. Each instruction is a single byte. The top nibble picks one of sixteen operations, and two 2-bit fields pick a source and a destination among four 8-bit registers. A fixed combinational decode of the opcode and the current step drives every control line. There is no microcode store. The ALU keeps a zero flag and a carry flag. The only conditional branches test one of these two flags.

After an active-low reset, a boot sequencer copies a read-only boot image, one word per cycle, into instruction RAM. It then hands control to the core, which starts fetching at address 0. The sequencer cannot write instruction RAM again until the next reset.

Conditional branches whose condition is false retire one cycle early. The PC simply increments. A halt instruction freezes the core and raises `halted_o`.

Top module: `hw8_cpu`

## Requirements
- R1: After reset deasserts, `imem_we_o` is high for exactly BOOT_LEN consecutive cycles. In the k-th of those cycles it writes ROM word k (`boot_addr_o` = k) to instruction address k.
- R2: After the boot copy, the first fetch is at address 0. `imem_we_o` stays low from then until the next reset.
- R3: Instruction encoding is [7:4] opcode, [3:2] source register rs, [1:0] destination register rd. The opcodes are: 0 NOP, 1 MOV, 2 ADD, 3 SUB, 4 AND, 5 OR, 6 XOR, 7 NOT, 8 LD, 9 ST, A LDI, B JMP, C JZ, D JC, E CMP, F HLT.
- R4: ALU results are written to rd. ADD, SUB, AND, OR and XOR give rd op rs. MOV gives rs. NOT gives the complement of rs. NOP and CMP leave every register unchanged.
- R5: ADD sets carry to the carry-out. SUB and CMP compute rd - rs and set carry when there is no borrow (rd >= rs). AND, OR, XOR and NOT clear carry. All of these set zero when the 8-bit result is 0. Every other opcode leaves both flags unchanged. Both flags reset to 0.
- R6: LDI loads the byte that follows it into rd and advances the PC by 2.
- R7: LD loads rd from data address reg[rs]. ST writes reg[rd] to data address reg[rs], with `dmem_we_o` high for one cycle. Instruction memory is never used for data.
- R8: NOP, MOV, ALU operations, CMP, LD and ST take 3 cycles. LDI takes 4.
- R9: A JZ or JC whose flag is clear takes 3 cycles, and the PC increments. A JZ or JC whose flag is set, and a JMP, take 4 cycles and load the PC from reg[rs].
- R10: HLT raises `halted_o` 3 cycles after its fetch begins. After that the PC and `imem_addr_o` hold, and no memory is written until reset.
- R11: A cycle that writes data RAM writes no register and no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| boot_addr_o | output | IAW | Boot ROM read address |
| boot_data_i | input | 8 | Boot ROM read data (combinational) |
| imem_addr_o | output | IAW | Instruction RAM address |
| imem_wdata_o | output | 8 | Instruction RAM write data (boot copy) |
| imem_we_o | output | 1 | Instruction RAM write enable |
| imem_rdata_i | input | 8 | Instruction RAM read data (combinational) |
| dmem_addr_o | output | DAW | Data RAM address |
| dmem_wdata_o | output | 8 | Data RAM write data |
| dmem_we_o | output | 1 | Data RAM write enable |
| dmem_rdata_i | input | 8 | Data RAM read data (combinational) |
| halted_o | output | 1 | Core has executed HLT |

## Verification
The bench treats every program as one stimulus, measured from reset release. `halted_o` is due exactly BOOT_LEN cycles plus the summed per-instruction costs later: 3 for plain operations, 4 for LDI and taken branches, 3 for HLT. It counts rising edges and samples on falling edges, so a count off by one cycle is reported.

For the flag sweep, the program runs one JZ and two JC, each jumping to the next instruction. The measured cycle count therefore equals a base count plus Z + 2·C, and both flags of every operation are checked through timing alone. Stored results are read from the bench's data array after halt. The boot copy is checked write by write as it happens.

// File: rtl/hw8_pkg.sv
package hw8_pkg;
  localparam int DW = 8;
  localparam int NREG = 4;

  typedef enum logic [3:0] {
    OP_NOP = 4'h0, OP_MOV = 4'h1, OP_ADD = 4'h2, OP_SUB = 4'h3,
    OP_AND = 4'h4, OP_OR  = 4'h5, OP_XOR = 4'h6, OP_NOT = 4'h7,
    OP_LD  = 4'h8, OP_ST  = 4'h9, OP_LDI = 4'hA, OP_JMP = 4'hB,
    OP_JZ  = 4'hC, OP_JC  = 4'hD, OP_CMP = 4'hE, OP_HLT = 4'hF
  } opcode_e;

  typedef enum logic [2:0] {
    ST_BOOT, ST_FETCH, ST_DECODE, ST_EXEC, ST_EXEC2, ST_HALT
  } step_e;

  typedef enum logic [1:0] {WB_ALU, WB_DMEM, WB_IMEM} wb_sel_e;

  typedef struct packed {
    logic    rf_we;
    wb_sel_e wb_sel;
    logic    flags_we;
    logic    dmem_we;
    logic    pc_inc;
    logic    pc_load;
    logic    ir_load;
    step_e   next;
  } ctrl_t;
endpackage

// File: rtl/hw8_boot_seq.sv
module hw8_boot_seq #(
  parameter int LEN = 64,
  parameter int AW  = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  output logic          active_o,
  output logic          last_o,
  output logic [AW-1:0] addr_o
);
  localparam logic [AW-1:0] LAST = AW'(LEN - 1);

  logic [AW-1:0] idx_q;
  logic          done_q;

  // done_q is sticky: only reset reopens the write path
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q  <= '0;
      done_q <= 1'b0;
    end else if (!done_q) begin
      if (idx_q == LAST) done_q <= 1'b1;
      else               idx_q  <= idx_q + 1'b1;
    end
  end

  assign active_o = !done_q;
  assign last_o   = !done_q && (idx_q == LAST);
  assign addr_o   = idx_q;
endmodule

// File: rtl/hw8_regfile.sv
module hw8_regfile #(
  parameter int DW   = 8,
  parameter int NREG = 4,
  localparam int RW  = $clog2(NREG)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [RW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [RW-1:0] raddr_a_i,
  input  logic [RW-1:0] raddr_b_i,
  output logic [DW-1:0] rdata_a_o,
  output logic [DW-1:0] rdata_b_o
);
  logic [DW-1:0] regs_q [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                  regs_q[g] <= '0;
      else if (we_i && waddr_i == RW'(g))           regs_q[g] <= wdata_i;
    end
  end

  assign rdata_a_o = regs_q[raddr_a_i];
  assign rdata_b_o = regs_q[raddr_b_i];
endmodule

// File: rtl/hw8_alu.sv
module hw8_alu
  import hw8_pkg::*;
(
  input  opcode_e       op_i,
  input  logic [DW-1:0] a_i,   // rd
  input  logic [DW-1:0] b_i,   // rs
  output logic [DW-1:0] res_o,
  output logic          z_o,
  output logic          c_o
);
  logic [DW:0] sum;

  always_comb begin
    sum   = '0;
    res_o = a_i;
    c_o   = 1'b0;
    case (op_i)
      OP_MOV: res_o = b_i;
      OP_ADD: begin
        sum   = {1'b0, a_i} + {1'b0, b_i};
        res_o = sum[DW-1:0];
        c_o   = sum[DW];
      end
      OP_SUB, OP_CMP: begin
        sum   = {1'b0, a_i} - {1'b0, b_i};
        res_o = sum[DW-1:0];
        c_o   = !sum[DW];   // carry = no borrow
      end
      OP_AND: res_o = a_i & b_i;
      OP_OR:  res_o = a_i | b_i;
      OP_XOR: res_o = a_i ^ b_i;
      OP_NOT: res_o = ~b_i;
      default: ;
    endcase
    z_o = (res_o == '0);
  end
endmodule

// File: rtl/hw8_ctrl.sv
module hw8_ctrl
  import hw8_pkg::*;
(
  input  step_e   step_i,
  input  opcode_e op_i,
  input  logic    zf_i,
  input  logic    cf_i,
  input  logic    boot_last_i,
  output ctrl_t   ctrl_o
);
  always_comb begin
    ctrl_o      = '0;
    ctrl_o.next = step_i;
    case (step_i)
      ST_BOOT:   if (boot_last_i) ctrl_o.next = ST_FETCH;
      ST_FETCH:  begin ctrl_o.ir_load = 1'b1; ctrl_o.next = ST_DECODE; end
      ST_DECODE: ctrl_o.next = ST_EXEC;
      ST_EXEC: begin
        ctrl_o.next   = ST_FETCH;
        ctrl_o.pc_inc = 1'b1;
        case (op_i)
          OP_MOV: ctrl_o.rf_we = 1'b1;
          OP_ADD, OP_SUB, OP_AND, OP_OR, OP_XOR, OP_NOT: begin
            ctrl_o.rf_we    = 1'b1;
            ctrl_o.flags_we = 1'b1;
          end
          OP_CMP: ctrl_o.flags_we = 1'b1;
          OP_LD: begin ctrl_o.rf_we = 1'b1; ctrl_o.wb_sel = WB_DMEM; end
          OP_ST:  ctrl_o.dmem_we = 1'b1;
          OP_LDI: ctrl_o.next = ST_EXEC2;
          // early exit: a false condition retires here with PC+1
          OP_JMP, OP_JZ, OP_JC:
            if (op_i == OP_JMP || (op_i == OP_JZ && zf_i) || (op_i == OP_JC && cf_i)) begin
              ctrl_o.pc_inc = 1'b0;
              ctrl_o.next   = ST_EXEC2;
            end
          OP_HLT: begin ctrl_o.pc_inc = 1'b0; ctrl_o.next = ST_HALT; end
          default: ;
        endcase
      end
      ST_EXEC2: begin
        ctrl_o.next = ST_FETCH;
        if (op_i == OP_LDI) begin
          ctrl_o.rf_we  = 1'b1;
          ctrl_o.wb_sel = WB_IMEM;
          ctrl_o.pc_inc = 1'b1;
        end else begin
          ctrl_o.pc_load = 1'b1;
        end
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/hw8_cpu.sv
module hw8_cpu
  import hw8_pkg::*;
#(
  parameter int IAW      = 8,
  parameter int DAW      = 8,
  parameter int BOOT_LEN = 64
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  output logic [IAW-1:0] boot_addr_o,
  input  logic [DW-1:0]  boot_data_i,
  output logic [IAW-1:0] imem_addr_o,
  output logic [DW-1:0]  imem_wdata_o,
  output logic           imem_we_o,
  input  logic [DW-1:0]  imem_rdata_i,
  output logic [DAW-1:0] dmem_addr_o,
  output logic [DW-1:0]  dmem_wdata_o,
  output logic           dmem_we_o,
  input  logic [DW-1:0]  dmem_rdata_i,
  output logic           halted_o
);
  localparam int RW = $clog2(NREG);

  step_e          state_q;
  logic [IAW-1:0] pc_q;
  logic [7:0]     ir_q;
  logic           zf_q, cf_q;

  logic           boot_active, boot_last;
  logic [IAW-1:0] boot_addr;
  ctrl_t          ctrl;
  opcode_e        op;
  logic [RW-1:0]  rs_sel, rd_sel;
  logic [DW-1:0]  rs_data, rd_data, alu_res, wb_data;
  logic           alu_z, alu_c;
  logic           rf_we, flags_we;

  assign op     = opcode_e'(ir_q[7:4]);
  assign rs_sel = ir_q[3:2];
  assign rd_sel = ir_q[1:0];

  hw8_boot_seq #(.LEN(BOOT_LEN), .AW(IAW)) u_boot (
    .clk_i, .rst_ni,
    .active_o(boot_active), .last_o(boot_last), .addr_o(boot_addr)
  );

  hw8_ctrl u_ctrl (
    .step_i(state_q), .op_i(op), .zf_i(zf_q), .cf_i(cf_q),
    .boot_last_i(boot_last), .ctrl_o(ctrl)
  );

  hw8_alu u_alu (
    .op_i(op), .a_i(rd_data), .b_i(rs_data),
    .res_o(alu_res), .z_o(alu_z), .c_o(alu_c)
  );

  always_comb begin
    case (ctrl.wb_sel)
      WB_DMEM: wb_data = dmem_rdata_i;
      WB_IMEM: wb_data = imem_rdata_i;
      default: wb_data = alu_res;
    endcase
  end

  assign rf_we    = ctrl.rf_we;
  assign flags_we = ctrl.flags_we;

  hw8_regfile #(.DW(DW), .NREG(NREG)) u_rf (
    .clk_i, .rst_ni,
    .we_i(rf_we), .waddr_i(rd_sel), .wdata_i(wb_data),
    .raddr_a_i(rs_sel), .raddr_b_i(rd_sel),
    .rdata_a_o(rs_data), .rdata_b_o(rd_data)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_BOOT;
      pc_q    <= '0;
      ir_q    <= '0;
      zf_q    <= 1'b0;
      cf_q    <= 1'b0;
    end else begin
      state_q <= ctrl.next;
      if (ctrl.ir_load)      ir_q <= imem_rdata_i;
      if (ctrl.pc_load)      pc_q <= rs_data[IAW-1:0];
      else if (ctrl.pc_inc)  pc_q <= pc_q + 1'b1;
      if (flags_we) begin
        zf_q <= alu_z;
        cf_q <= alu_c;
      end
    end
  end

  assign boot_addr_o  = boot_addr;
  assign imem_addr_o  = boot_active ? boot_addr : pc_q;
  assign imem_wdata_o = boot_data_i;
  assign imem_we_o    = boot_active;
  assign dmem_addr_o  = rs_data[DAW-1:0];
  assign dmem_wdata_o = rd_data;
  assign dmem_we_o    = ctrl.dmem_we;
  assign halted_o     = (state_q == ST_HALT);
endmodule

// File: rtl/hw8_cpu_chk.sv
module hw8_cpu_chk
  import hw8_pkg::*;
#(
  parameter int IAW = 8
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic           imem_we_o,
  input logic           dmem_we_o,
  input logic           halted_o,
  input logic [IAW-1:0] imem_addr_o,
  input step_e          state_q,
  input logic [IAW-1:0] pc_q,
  input logic [7:0]     ir_q,
  input logic           zf_q,
  input logic           cf_q,
  input logic           rf_we,
  input logic           flags_we
);
  // R2
  boot_we_only_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    imem_we_o |-> state_q == ST_BOOT);

  // R2
  no_reboot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q != ST_BOOT |=> state_q != ST_BOOT);

  // R2
  first_fetch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_FETCH && $past(state_q) == ST_BOOT) |-> pc_q == '0);

  // R10
  halt_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halted_o |=> halted_o && $stable(pc_q) && $stable(imem_addr_o) && !dmem_we_o && !imem_we_o);

  // R11
  split_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dmem_we_o |-> !rf_we && !flags_we);

  // R9
  br_skip_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_EXEC && ((ir_q[7:4] == 4'hC && !zf_q) || (ir_q[7:4] == 4'hD && !cf_q)))
    |=> state_q == ST_FETCH && pc_q == $past(pc_q) + 1'b1);

  // R9
  br_take_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_EXEC && ir_q[7:4] == 4'hB) |=> state_q == ST_EXEC2 && $stable(pc_q));
endmodule

bind hw8_cpu hw8_cpu_chk #(.IAW(IAW)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .imem_we_o(imem_we_o), .dmem_we_o(dmem_we_o),
  .halted_o(halted_o), .imem_addr_o(imem_addr_o), .state_q(state_q), .pc_q(pc_q),
  .ir_q(ir_q), .zf_q(zf_q), .cf_q(cf_q), .rf_we(rf_we), .flags_we(flags_we)
);

// File: tb/hw8_cpu_tb.sv
module hw8_cpu_tb;
  localparam int BLEN = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic [7:0] boot_addr, boot_data, imem_addr, imem_wdata, imem_rdata;
  logic [7:0] dmem_addr, dmem_wdata, dmem_rdata;
  logic       imem_we, dmem_we, halted;

  logic [7:0] rom  [256];
  logic [7:0] imem [256];
  logic [7:0] dmem [256];

  assign boot_data  = rom[boot_addr];
  assign imem_rdata = imem[imem_addr];
  assign dmem_rdata = dmem[dmem_addr];

  hw8_cpu #(.IAW(8), .DAW(8), .BOOT_LEN(BLEN)) u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .boot_addr_o(boot_addr), .boot_data_i(boot_data),
    .imem_addr_o(imem_addr), .imem_wdata_o(imem_wdata), .imem_we_o(imem_we),
    .imem_rdata_i(imem_rdata),
    .dmem_addr_o(dmem_addr), .dmem_wdata_o(dmem_wdata), .dmem_we_o(dmem_we),
    .dmem_rdata_i(dmem_rdata), .halted_o(halted)
  );

  int n_chk = 0, n_err = 0;
  int n_iw = 0, bad_iw = 0, n_dw = 0;

  always @(posedge clk) begin
    if (imem_we) imem[imem_addr] <= imem_wdata;
    if (dmem_we) dmem[dmem_addr] <= dmem_wdata;
    if (rst_n) begin
      if (imem_we) begin
        if (imem_addr != 8'(n_iw) || boot_addr != 8'(n_iw) || imem_wdata != rom[n_iw]) bad_iw++;
        n_iw++;
      end
      if (dmem_we) n_dw++;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // reset, release at a falling edge, count rising edges until halted
  task automatic run(output int cyc);
    rst_n = 1'b0;
    n_iw = 0; bad_iw = 0; n_dw = 0;
    for (int i = 0; i < 256; i++) imem[i] = 8'h00;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    cyc = 0;
    while (!halted && cyc < 400) begin
      @(posedge clk);
      cyc++;
      @(negedge clk);
    end
  endtask

  function automatic void model(input logic [3:0] op, input logic [7:0] a, input logic [7:0] b,
                                output logic [7:0] r, output bit z, output bit c);
    logic [8:0] s;
    r = a; z = 1'b0; c = 1'b0;
    case (op)
      4'h1: r = b;
      4'h2: begin s = {1'b0, a} + {1'b0, b}; r = s[7:0]; c = s[8]; z = (r == 0); end
      4'h3: begin r = a - b; c = (a >= b); z = (r == 0); end
      4'h4: begin r = a & b; z = (r == 0); end
      4'h5: begin r = a | b; z = (r == 0); end
      4'h6: begin r = a ^ b; z = (r == 0); end
      4'h7: begin r = ~b;    z = (r == 0); end
      4'hE: begin c = (a >= b); z = (a == b); end
      default: ;
    endcase
  endfunction

  initial begin
    #(190000 * 20);
    n_err++;
    $display("FAIL watchdog: actual %0d expected %0d", n_chk, 0);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  logic [7:0] vals [12] = '{8'h00, 8'h01, 8'h02, 8'h7F, 8'h80, 8'h81,
                            8'hFE, 8'hFF, 8'h55, 8'hAA, 8'h0F, 8'h33};
  logic [3:0] ops  [9]  = '{4'h0, 4'h1, 4'h2, 4'h3, 4'h4, 4'h5, 4'h6, 4'h7, 4'hE};

  initial begin
    int cyc;
    logic [7:0] r, hold_addr;
    bit z, c;
    for (int i = 0; i < 256; i++) begin rom[i] = 8'h00; dmem[i] = 8'h00; end

    // reset state (R1)
    @(negedge clk);
    chk(halted == 1'b0, "R10 halted in reset", halted, 0);
    chk(imem_we == 1'b1 && imem_addr == 8'h00, "R1 boot write at addr 0 in reset", imem_addr, 0);

    // LD / JMP / ST program, encoding per R3
    rom[0] = 8'hA2; rom[1] = 8'h40; rom[2] = 8'h89; rom[3] = 8'hA3; rom[4] = 8'h07;
    rom[5] = 8'hBC; rom[6] = 8'hF0; rom[7] = 8'hA0; rom[8] = 8'h90; rom[9] = 8'h91;
    rom[10] = 8'hF0;
    dmem[8'h40] = 8'h3C;
    run(cyc);
    chk(n_iw == BLEN, "R1 boot write count", n_iw, BLEN);
    chk(bad_iw == 0, "R1 boot write address/data order", bad_iw, 0);
    begin
      int diff = 0;
      for (int i = 0; i < BLEN; i++) if (imem[i] != rom[i]) diff++;
      chk(diff == 0, "R1 image copied", diff, 0);
    end
    chk(cyc == BLEN + 25, "R6 R8 R9 JMP/LD/LDI cycle total", cyc, BLEN + 25);
    chk(dmem[8'h90] == 8'h3C, "R7 LD then ST via LDI address (R6)", dmem[8'h90], 8'h3C);
    chk(n_dw == 1, "R7 R11 single data write", n_dw, 1);

    // halt freeze
    hold_addr = imem_addr;
    repeat (12) @(negedge clk);
    chk(halted == 1'b1, "R10 halted holds", halted, 1);
    chk(imem_addr == hold_addr, "R10 PC frozen", imem_addr, hold_addr);
    chk(n_dw == 1, "R10 no write after halt", n_dw, 1);
    chk(n_iw == BLEN, "R2 no instruction write after handover", n_iw, BLEN);

    // flag/result sweep; JZ once, JC twice, all targets fall through
    rom[0] = 8'hA0; rom[2] = 8'hA1; rom[5] = 8'hA2; rom[6] = 8'h80; rom[7] = 8'h98;
    rom[8] = 8'hA3; rom[9] = 8'd11; rom[10] = 8'hCC; rom[11] = 8'hA3; rom[12] = 8'd14;
    rom[13] = 8'hDC; rom[14] = 8'hA3; rom[15] = 8'd17; rom[16] = 8'hDC; rom[17] = 8'hF0;
    for (int o = 0; o < 9; o++) begin
      for (int i = 0; i < 12; i++) begin
        for (int j = 0; j < 12; j++) begin
          rom[1] = vals[i];
          rom[3] = vals[j];
          rom[4] = {ops[o], 4'b0100};  // R3: rs = r1, rd = r0
          model(ops[o], vals[i], vals[j], r, z, c);
          run(cyc);
          chk(dmem[8'h80] == r, $sformatf("R4 op %0h a %0h b %0h result", ops[o], vals[i], vals[j]),
              dmem[8'h80], r);
          chk(cyc == BLEN + 42 + int'(z) + 2 * int'(c),
              $sformatf("R5 R9 op %0h a %0h b %0h flag timing", ops[o], vals[i], vals[j]),
              cyc, BLEN + 42 + int'(z) + 2 * int'(c));
          chk(n_dw == 1 && n_iw == BLEN, "R11 R2 write counts", n_dw, 1);
        end
      end
    end

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule